// File: doc/BRIEF.md
# Segment-Mapped Address Translation Front End

This block decides, for every virtual address a core issues, which of three routes produces the physical address. If translation is switched off in the general configuration register, the address passes straight through with read, write and execute rights. If translation is on and a kernel-mode access falls in a 256 MB segment that the MMU configuration register marks as directly mapped, the physical address is built from a 4-bit base nibble for that segment and the low 28 address bits. The page TLB is not consulted on this route.

Every other access is forwarded to the page TLB's combinational lookup port. The TLB's miss flag, physical address, permissions and fault vector come back through the block unchanged. The request is registered once at the block's input, and the routing decision is combinational on that register. The flat route and the segment route therefore complete in the same cycle in which a TLB lookup would be issued. The sixteen base nibbles sit in two 32-bit kernel-base registers. All configuration inputs are live levels, and the block has no access for software.

Top module: `seg_xlat_front`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid` and `tlb_req_valid` are low, whatever `in_valid` does during reset.
- R2: When bits 2 and 3 of `gc_cfg` are both clear, a valid result has `out_route` 0, `out_paddr` equal to the request address, `out_perm` 3'b111, `out_miss` 0 and `out_vec` 0, and no TLB request is made. This holds whatever the mode and `mm_cfg` are. In `out_perm`, bit 0 is read, bit 1 is write and bit 2 is execute.
- R3: Translation is on when bit 2 or bit 3 of `gc_cfg` is set, either one alone being enough. The other bits of `gc_cfg` have no effect on the result.
- R4: With translation on, a kernel access (`in_user` 0) whose segment `vaddr[31:28]` has its bit set in `mm_cfg` gives `out_route` 1, `out_paddr` = {base nibble, `vaddr[27:0]`}, `out_perm` 3'b111, `out_miss` 0 and `out_vec` 0, and no TLB request.
- R5: Segment s in 0..7 takes its nibble from `kbase_lo[4s+3:4s]`, and segment s in 8..15 from `kbase_hi[4(s-8)+3:4(s-8)]`.
- R6: A user-mode access is never segment-mapped. With translation on, it takes the TLB route even when its segment bit in `mm_cfg` is set.
- R7: On the TLB route, `out_route` is 2 and `tlb_req_valid` is high. `tlb_vaddr`, `tlb_kind` and `tlb_user` equal the request, and `out_miss`, `out_paddr`, `out_perm` and `out_vec` equal the TLB's response in the same cycle.
- R8: A request sampled with `in_valid` high at a rising edge has its result on the outputs with `out_valid` high throughout the next cycle, on every route. A rising edge with `in_valid` low is followed by a cycle with `out_valid` low.
- R9: The access kind (0 load, 1 store, 2 fetch) does not change the route or the flat or segment result. It is forwarded unchanged to the TLB.
- R10: `tlb_req_valid` is low whenever `out_valid` is low or the route is not the TLB route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_vaddr | input | 32 | Virtual address |
| in_user | input | 1 | 1 = user mode, 0 = kernel mode |
| in_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| gc_cfg | input | 32 | General configuration; bits 2 and 3 enable translation |
| mm_cfg | input | 32 | MMU configuration; bit s marks segment s as directly mapped |
| kbase_lo | input | 32 | Base nibbles for segments 0..7 |
| kbase_hi | input | 32 | Base nibbles for segments 8..15 |
| tlb_req_valid | output | 1 | Page TLB lookup request |
| tlb_vaddr | output | 32 | Registered request address toward the TLB |
| tlb_user | output | 1 | Registered mode toward the TLB |
| tlb_kind | output | 2 | Registered access kind toward the TLB |
| tlb_miss | input | 1 | TLB miss or fault indication |
| tlb_paddr | input | 32 | TLB physical address |
| tlb_perm | input | 3 | TLB permissions (bit 0 read, 1 write, 2 execute) |
| tlb_vec | input | 4 | TLB fault vector |
| out_valid | output | 1 | Result valid |
| out_miss | output | 1 | Miss flag |
| out_paddr | output | 32 | Physical address |
| out_perm | output | 3 | Permissions (bit 0 read, 1 write, 2 execute) |
| out_vec | output | 4 | Fault vector |
| out_route | output | 2 | Route taken: 0 flat, 1 segment, 2 TLB |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and 4-bit segment numbers, which give sixteen segments whose bases are split across two 32-bit registers. With these values the bench can sweep all sixteen segments, so every nibble position in both base registers and the boundary between segment 7 and segment 8 are exercised. It also runs user and kernel accesses on the same segment and every single enable bit of the general register. A bench-side TLB model returns address-dependent responses, which makes a wrong route or a stale field show up in the outputs.

// File: rtl/segx_pkg.sv
package segx_pkg;

    // Route taken for a request; the encoding is visible on out_route.
    typedef enum logic [1:0] {
        ROUTE_FLAT = 2'd0,
        ROUTE_SEG  = 2'd1,
        ROUTE_PAGE = 2'd2
    } route_e;

    // Access kinds as carried on in_kind / tlb_kind.
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    localparam int unsigned KIND_W    = 2;
    localparam int unsigned PERM_W    = 3;
    localparam logic [PERM_W-1:0] PERM_FULL = 3'b111;

    // General config bits; either one turns translation on.
    localparam int unsigned GC_EN_A = 2;
    localparam int unsigned GC_EN_B = 3;

    function automatic route_e pick_route(input logic en,
                                          input logic direct,
                                          input logic user);
        if (!en) begin
            return ROUTE_FLAT;
        end else if (direct && !user) begin
            return ROUTE_SEG;
        end
        return ROUTE_PAGE;
    endfunction

endpackage

// File: rtl/segx_req_reg.sv
module segx_req_reg #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned KIND_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_vaddr,
    input  logic              in_user,
    input  logic [KIND_W-1:0] in_kind,
    output logic              q_valid,
    output logic [ADDR_W-1:0] q_vaddr,
    output logic              q_user,
    output logic [KIND_W-1:0] q_kind
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_vaddr <= '0;
            q_user  <= 1'b0;
            q_kind  <= '0;
        end else begin
            q_valid <= in_valid;
            if (in_valid) begin
                q_vaddr <= in_vaddr;
                q_user  <= in_user;
                q_kind  <= in_kind;
            end
        end
    end

endmodule

// File: rtl/segx_base_sel.sv
module segx_base_sel #(
    parameter int unsigned SEG_BITS = 4,
    localparam int unsigned NSEG = 1 << SEG_BITS,
    localparam int unsigned HALF = NSEG / 2,
    localparam int unsigned KB_W = HALF * SEG_BITS
) (
    input  logic [KB_W-1:0]     kbase_lo,
    input  logic [KB_W-1:0]     kbase_hi,
    input  logic [SEG_BITS-1:0] seg,
    output logic [SEG_BITS-1:0] base
);

    logic [SEG_BITS-1:0] nib [NSEG];

    // Lower half of the segments reads the low register, upper half the high one.
    for (genvar g = 0; g < NSEG; g++) begin : g_nib
        if (g < HALF) begin : g_lo
            assign nib[g] = kbase_lo[g*SEG_BITS +: SEG_BITS];
        end else begin : g_hi
            assign nib[g] = kbase_hi[(g-HALF)*SEG_BITS +: SEG_BITS];
        end
    end

    assign base = nib[seg];

endmodule

// File: rtl/segx_route.sv
module segx_route
    import segx_pkg::*;
#(
    parameter int unsigned SEG_BITS = 4,
    parameter int unsigned CFG_W    = 32,
    localparam int unsigned NSEG = 1 << SEG_BITS
) (
    input  logic [CFG_W-1:0]    gc_cfg,
    input  logic [CFG_W-1:0]    mm_cfg,
    input  logic                user,
    input  logic [SEG_BITS-1:0] seg,
    output route_e              route
);

    logic            xlat_on;
    logic [NSEG-1:0] seg_map;
    logic            unused_cfg_bits;

    assign xlat_on         = gc_cfg[GC_EN_A] | gc_cfg[GC_EN_B];
    assign seg_map         = mm_cfg[NSEG-1:0];
    assign unused_cfg_bits = ^{gc_cfg, mm_cfg};
    assign route           = pick_route(xlat_on, seg_map[seg], user);

endmodule

// File: rtl/segx_result.sv
module segx_result
    import segx_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned SEG_BITS = 4,
    parameter int unsigned VEC_W    = 4,
    localparam int unsigned LOW_W = ADDR_W - SEG_BITS
) (
    input  logic                q_valid,
    input  route_e              route,
    input  logic [ADDR_W-1:0]   q_vaddr,
    input  logic [SEG_BITS-1:0] base,
    input  logic                tlb_miss,
    input  logic [ADDR_W-1:0]   tlb_paddr,
    input  logic [PERM_W-1:0]   tlb_perm,
    input  logic [VEC_W-1:0]    tlb_vec,
    output logic                tlb_req_valid,
    output logic                out_miss,
    output logic [ADDR_W-1:0]   out_paddr,
    output logic [PERM_W-1:0]   out_perm,
    output logic [VEC_W-1:0]    out_vec
);

    assign tlb_req_valid = q_valid && (route == ROUTE_PAGE);

    always_comb begin
        out_miss  = 1'b0;
        out_paddr = '0;
        out_perm  = '0;
        out_vec   = '0;
        if (q_valid) begin
            unique case (route)
                ROUTE_FLAT: begin
                    out_paddr = q_vaddr;
                    out_perm  = PERM_FULL;
                end
                ROUTE_SEG: begin
                    out_paddr = {base, q_vaddr[LOW_W-1:0]};
                    out_perm  = PERM_FULL;
                end
                default: begin
                    out_miss  = tlb_miss;
                    out_paddr = tlb_paddr;
                    out_perm  = tlb_perm;
                    out_vec   = tlb_vec;
                end
            endcase
        end
    end

endmodule

// File: rtl/seg_xlat_front.sv
module seg_xlat_front
    import segx_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned SEG_BITS = 4,
    parameter int unsigned CFG_W    = 32,
    parameter int unsigned VEC_W    = 4,
    localparam int unsigned NSEG = 1 << SEG_BITS,
    localparam int unsigned KB_W = (NSEG / 2) * SEG_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_vaddr,
    input  logic              in_user,
    input  logic [1:0]        in_kind,
    input  logic [CFG_W-1:0]  gc_cfg,
    input  logic [CFG_W-1:0]  mm_cfg,
    input  logic [KB_W-1:0]   kbase_lo,
    input  logic [KB_W-1:0]   kbase_hi,
    output logic              tlb_req_valid,
    output logic [ADDR_W-1:0] tlb_vaddr,
    output logic              tlb_user,
    output logic [1:0]        tlb_kind,
    input  logic              tlb_miss,
    input  logic [ADDR_W-1:0] tlb_paddr,
    input  logic [2:0]        tlb_perm,
    input  logic [VEC_W-1:0]  tlb_vec,
    output logic              out_valid,
    output logic              out_miss,
    output logic [ADDR_W-1:0] out_paddr,
    output logic [2:0]        out_perm,
    output logic [VEC_W-1:0]  out_vec,
    output logic [1:0]        out_route
);

    logic                q_valid;
    logic [ADDR_W-1:0]   q_vaddr;
    logic                q_user;
    logic [KIND_W-1:0]   q_kind;
    logic [SEG_BITS-1:0] q_seg;
    logic [SEG_BITS-1:0] seg_base;
    route_e              route;

    segx_req_reg #(
        .ADDR_W (ADDR_W),
        .KIND_W (KIND_W)
    ) u_req (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_vaddr (in_vaddr),
        .in_user  (in_user),
        .in_kind  (in_kind),
        .q_valid  (q_valid),
        .q_vaddr  (q_vaddr),
        .q_user   (q_user),
        .q_kind   (q_kind)
    );

    assign q_seg = q_vaddr[ADDR_W-1 -: SEG_BITS];

    segx_route #(
        .SEG_BITS (SEG_BITS),
        .CFG_W    (CFG_W)
    ) u_route (
        .gc_cfg (gc_cfg),
        .mm_cfg (mm_cfg),
        .user   (q_user),
        .seg    (q_seg),
        .route  (route)
    );

    segx_base_sel #(
        .SEG_BITS (SEG_BITS)
    ) u_base (
        .kbase_lo (kbase_lo),
        .kbase_hi (kbase_hi),
        .seg      (q_seg),
        .base     (seg_base)
    );

    segx_result #(
        .ADDR_W   (ADDR_W),
        .SEG_BITS (SEG_BITS),
        .VEC_W    (VEC_W)
    ) u_result (
        .q_valid       (q_valid),
        .route         (route),
        .q_vaddr       (q_vaddr),
        .base          (seg_base),
        .tlb_miss      (tlb_miss),
        .tlb_paddr     (tlb_paddr),
        .tlb_perm      (tlb_perm),
        .tlb_vec       (tlb_vec),
        .tlb_req_valid (tlb_req_valid),
        .out_miss      (out_miss),
        .out_paddr     (out_paddr),
        .out_perm      (out_perm),
        .out_vec       (out_vec)
    );

    assign tlb_vaddr = q_vaddr;
    assign tlb_user  = q_user;
    assign tlb_kind  = q_kind;
    assign out_valid = q_valid;
    assign out_route = q_valid ? route : ROUTE_FLAT;

endmodule

// File: rtl/segx_chk.sv
module segx_chk
    import segx_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned SEG_BITS = 4,
    parameter int unsigned CFG_W    = 32,
    parameter int unsigned VEC_W    = 4,
    localparam int unsigned LOW_W = ADDR_W - SEG_BITS
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [CFG_W-1:0]  gc_cfg,
    input logic              tlb_req_valid,
    input logic [ADDR_W-1:0] tlb_vaddr,
    input logic              tlb_user,
    input logic              tlb_miss,
    input logic [ADDR_W-1:0] tlb_paddr,
    input logic [2:0]        tlb_perm,
    input logic [VEC_W-1:0]  tlb_vec,
    input logic              out_valid,
    input logic              out_miss,
    input logic [ADDR_W-1:0] out_paddr,
    input logic [2:0]        out_perm,
    input logic [VEC_W-1:0]  out_vec,
    input logic [1:0]        out_route
);

    // R2
    flat_pass_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !(gc_cfg[GC_EN_A] || gc_cfg[GC_EN_B]) |->
            out_paddr == tlb_vaddr && out_perm == PERM_FULL && !out_miss && !tlb_req_valid);

    // R4
    seg_low_bits_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_route == ROUTE_SEG |->
            out_paddr[LOW_W-1:0] == tlb_vaddr[LOW_W-1:0] && out_perm == PERM_FULL
            && !out_miss && out_vec == '0 && !tlb_req_valid);

    // R6
    user_to_page_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && tlb_user && (gc_cfg[GC_EN_A] || gc_cfg[GC_EN_B]) |-> tlb_req_valid);

    // R7
    page_echo_chk: assert property (@(posedge clk) disable iff (rst)
        tlb_req_valid |-> out_route == ROUTE_PAGE && out_miss == tlb_miss
            && out_paddr == tlb_paddr && out_perm == tlb_perm && out_vec == tlb_vec);

    // R8
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R8
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R10
    quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !tlb_req_valid);

endmodule

bind seg_xlat_front segx_chk #(
    .ADDR_W   (ADDR_W),
    .SEG_BITS (SEG_BITS),
    .CFG_W    (CFG_W),
    .VEC_W    (VEC_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .gc_cfg        (gc_cfg),
    .tlb_req_valid (tlb_req_valid),
    .tlb_vaddr     (tlb_vaddr),
    .tlb_user      (tlb_user),
    .tlb_miss      (tlb_miss),
    .tlb_paddr     (tlb_paddr),
    .tlb_perm      (tlb_perm),
    .tlb_vec       (tlb_vec),
    .out_valid     (out_valid),
    .out_miss      (out_miss),
    .out_paddr     (out_paddr),
    .out_perm      (out_perm),
    .out_vec       (out_vec),
    .out_route     (out_route)
);

// File: tb/seg_xlat_front_test.sv
`timescale 1ns/1ps
module seg_xlat_front_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_vaddr = '0;
    logic        in_user = 1'b0;
    logic [1:0]  in_kind = '0;
    logic [31:0] gc_cfg = '0;
    logic [31:0] mm_cfg = '0;
    logic [31:0] kbase_lo = '0;
    logic [31:0] kbase_hi = '0;
    logic        tlb_req_valid;
    logic [31:0] tlb_vaddr;
    logic        tlb_user;
    logic [1:0]  tlb_kind;
    logic        tlb_miss;
    logic [31:0] tlb_paddr;
    logic [2:0]  tlb_perm;
    logic [3:0]  tlb_vec;
    logic        out_valid;
    logic        out_miss;
    logic [31:0] out_paddr;
    logic [2:0]  out_perm;
    logic [3:0]  out_vec;
    logic [1:0]  out_route;

    always #4 clk = ~clk;

    seg_xlat_front uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_vaddr(in_vaddr),
        .in_user(in_user), .in_kind(in_kind), .gc_cfg(gc_cfg), .mm_cfg(mm_cfg),
        .kbase_lo(kbase_lo), .kbase_hi(kbase_hi), .tlb_req_valid(tlb_req_valid),
        .tlb_vaddr(tlb_vaddr), .tlb_user(tlb_user), .tlb_kind(tlb_kind),
        .tlb_miss(tlb_miss), .tlb_paddr(tlb_paddr), .tlb_perm(tlb_perm),
        .tlb_vec(tlb_vec), .out_valid(out_valid), .out_miss(out_miss),
        .out_paddr(out_paddr), .out_perm(out_perm), .out_vec(out_vec),
        .out_route(out_route)
    );

    // Bench-side page TLB: an arbitrary but address-dependent response.
    function automatic logic [39:0] tlb_model(input logic [31:0] va, input logic [1:0] k,
                                              input logic u);
        logic        m;
        logic [31:0] p;
        logic [2:0]  pr;
        logic [3:0]  v;
        m  = va[15] ^ va[3];
        p  = va ^ 32'h5A5A_E000;
        pr = va[2:0] ^ {1'b0, k};
        v  = va[7:4] ^ {3'b000, u};
        return {m, p, pr, v};
    endfunction

    always_comb {tlb_miss, tlb_paddr, tlb_perm, tlb_vec} = tlb_model(tlb_vaddr, tlb_kind, tlb_user);

    int vectors = 0;
    int fails   = 0;

    // Pending expectation for the request driven at the previous falling edge.
    logic        have_exp = 1'b0;
    string       e_tag;
    logic        e_valid, e_miss, e_req, e_user;
    logic [31:0] e_paddr, e_va;
    logic [2:0]  e_perm;
    logic [3:0]  e_vec;
    logic [1:0]  e_route, e_kind;

    // Values applied with the next request.
    logic        n_rst = 1'b1;
    logic [31:0] n_gc = '0, n_mm = '0, n_lo = '0, n_hi = '0;

    task automatic fail_line(input string tag, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        fails++;
        $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    endtask

    task automatic check_pending();
        if (!have_exp) return;
        vectors++;
        if (out_valid !== e_valid) fail_line(e_tag, "out_valid", 32'(out_valid), 32'(e_valid));
        if (tlb_req_valid !== e_req) fail_line(e_tag, "tlb_req_valid", 32'(tlb_req_valid), 32'(e_req));
        if (e_valid) begin
            if (out_route !== e_route) fail_line(e_tag, "out_route", 32'(out_route), 32'(e_route));
            if (out_paddr !== e_paddr) fail_line(e_tag, "out_paddr", out_paddr, e_paddr);
            if (out_perm !== e_perm) fail_line(e_tag, "out_perm", 32'(out_perm), 32'(e_perm));
            if (out_miss !== e_miss) fail_line(e_tag, "out_miss", 32'(out_miss), 32'(e_miss));
            if (out_vec !== e_vec) fail_line(e_tag, "out_vec", 32'(out_vec), 32'(e_vec));
            if (e_req) begin
                if (tlb_vaddr !== e_va) fail_line(e_tag, "tlb_vaddr", tlb_vaddr, e_va);
                if (tlb_kind !== e_kind) fail_line(e_tag, "tlb_kind", 32'(tlb_kind), 32'(e_kind));
                if (tlb_user !== e_user) fail_line(e_tag, "tlb_user", 32'(tlb_user), 32'(e_user));
            end
        end
    endtask

    task automatic step(input string tag, input logic v, input logic [31:0] va,
                        input logic u, input logic [1:0] k);
        int unsigned seg;
        int unsigned nib;
        logic        en;
        @(negedge clk);
        check_pending();
        rst = n_rst; gc_cfg = n_gc; mm_cfg = n_mm; kbase_lo = n_lo; kbase_hi = n_hi;
        in_valid = v; in_vaddr = va; in_user = u; in_kind = k;
        e_tag = tag; e_va = va; e_kind = k; e_user = u;
        e_valid = v && !n_rst;
        e_miss = 1'b0; e_vec = 4'd0; e_perm = 3'b111; e_req = 1'b0;
        en  = (n_gc & 32'h0000_000C) != 0;
        seg = va >> 28;
        if (!en) begin
            e_route = 2'd0; e_paddr = va;
        end else if (!u && ((n_mm >> seg) & 1) == 1) begin
            if (seg < 8) nib = (n_lo >> (4 * seg)) & 15;
            else         nib = (n_hi >> (4 * (seg - 8))) & 15;
            e_route = 2'd1;
            e_paddr = (32'(nib) << 28) | (va & 32'h0FFF_FFFF);
        end else begin
            e_route = 2'd2;
            {e_miss, e_paddr, e_perm, e_vec} = tlb_model(va, k, u);
            e_req = e_valid;
        end
        have_exp = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : stim
        n_lo = 32'h7F3A_C215;
        n_hi = 32'h9B0D_E486;
        n_mm = 32'hFFFF_FFFF;
        n_gc = 32'h0000_000C;
        // R1: requests offered during reset give nothing.
        n_rst = 1'b1;
        step("R1", 1'b1, 32'h1234_5678, 1'b0, 2'd0);
        step("R1", 1'b1, 32'h8000_0000, 1'b0, 2'd0);
        n_rst = 1'b0;
        step("R1", 1'b1, 32'h2000_0010, 1'b0, 2'd0);
        // R2: translation off, all modes and kinds pass flat.
        n_gc = 32'hFFFF_FFF3;
        step("R2", 1'b1, 32'hDEAD_BEEF, 1'b0, 2'd0);
        step("R2", 1'b1, 32'h0000_0004, 1'b1, 2'd1);
        step("R2", 1'b1, 32'hF00F_1234, 1'b0, 2'd2);
        n_mm = 32'h0;
        step("R2", 1'b1, 32'h7777_7777, 1'b1, 2'd2);
        // R3: each enable bit alone, other bits ignored.
        n_mm = 32'h0000_0010;
        n_gc = 32'h0000_0004;
        step("R3", 1'b1, 32'h4ABC_0000, 1'b0, 2'd0);
        n_gc = 32'h0000_0008;
        step("R3", 1'b1, 32'h4ABC_0008, 1'b0, 2'd0);
        n_gc = 32'hFFFF_FFF7;
        step("R3", 1'b1, 32'h5ABC_8000, 1'b0, 2'd1);
        n_gc = 32'h0000_0003;
        step("R3", 1'b1, 32'h4ABC_8000, 1'b0, 2'd1);
        // R4 R5 R9: every segment mapped, kernel, varying kinds.
        n_gc = 32'h0000_0004;
        n_mm = 32'h0000_FFFF;
        for (int s = 0; s < 16; s++) begin
            step(s < 8 ? "R5" : "R4", 1'b1, (32'(s) << 28) | 32'h0246_8ACE ^ 32'(s * 77),
                 1'b0, 2'(s % 3));
        end
        // R9: same address across all kinds.
        for (int k = 0; k < 3; k++) step("R9", 1'b1, 32'hB123_4567, 1'b0, 2'(k));
        // R6: user mode on mapped segments goes to the TLB.
        for (int s = 6; s < 10; s++) step("R6", 1'b1, (32'(s) << 28) | 32'h0000_A00C, 1'b1, 2'd0);
        // R7: alternating mapped and unmapped segments, kinds forwarded.
        n_mm = 32'h0000_5555;
        for (int s = 0; s < 16; s++) begin
            step("R7", 1'b1, (32'(s) << 28) | (32'(s) * 32'h0011_1119), 1'b0, 2'(s % 3));
        end
        // R8 R10: idle gaps, then back-to-back requests on all routes.
        step("R10", 1'b0, 32'h1000_0000, 1'b0, 2'd0);
        step("R10", 1'b0, 32'h3000_0000, 1'b1, 2'd0);
        step("R8", 1'b1, 32'h0000_0100, 1'b0, 2'd0);
        step("R8", 1'b1, 32'h1000_0100, 1'b0, 2'd2);
        n_gc = 32'h0;
        step("R8", 1'b1, 32'h2000_0100, 1'b0, 2'd1);
        n_gc = 32'h8;
        step("R10", 1'b0, 32'h1000_0000, 1'b0, 2'd0);
        step("R8", 1'b1, 32'hE000_F0F0, 1'b0, 2'd0);
        step("R10", 1'b0, 32'h0, 1'b0, 2'd0);
        @(negedge clk);
        check_pending();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule